// File: doc/BRIEF.md
# Thread Block Dispatcher

This block deals out the thread blocks of a launched grid to a fixed set of compute cores. A launch supplies three values: the number of blocks in the grid, the threads each block needs and the shared-memory bytes each block needs. For every core the dispatcher keeps three free counts: thread contexts, shared-memory bytes and block slots. A block goes to a core only when all three counts cover it at once. When a core reports that one of its blocks has finished, that block's resources go back to the core.

Blocks are offered one at a time on a valid/ready channel that names the target core and the block index. Indices go out in increasing order from zero. The target core is picked by a rotating search, so work spreads across the cores. The dispatcher keeps issuing until the grid is used up. It then raises a completion flag once the last outstanding block has been returned. A launch that could never fit even on an empty core raises an error flag instead of hanging.

The capacity of a core is set by parameters. The defaults give 1,536 threads, 49,152 bytes and 16 slots per core. A second profile of 2,048 threads and 16 slots is chosen by overriding the same parameters.

Top module: `block_dispatcher`

## Requirements
- R1: A launch whose thread count is 0, whose thread count exceeds the threads of a core, or whose shared-memory need exceeds the shared memory of a core is refused. launchError rises on the next cycle and stays high until another launch is accepted. No block is offered while it is high.
- R2: A block is offered to a core only when that core's free threads, free shared memory and free slots all cover the block at once. When no core qualifies, issueValid stays low. With 32-thread blocks that use no shared memory, a core holds 16 blocks (the slot limit). With 64-thread blocks of 8,192 bytes, a core holds 6 blocks (the shared-memory limit).
- R3: With 128-thread blocks of 520 bytes and the default parameters, each core accepts exactly 12 blocks before any block completes.
- R4: A pulse on coreDone[c] returns one block's threads, shared memory and slot to core c. A pending block can then be offered to that core.
- R5: Block indices are offered in increasing order starting at 0, each exactly once. In total, exactly gridBlocks blocks are handed over.
- R6: At most one block is transferred per clock, when issueValid and issueReady[issueCore] are both high. While the target is not ready, issueValid, issueCore and issueBlock hold steady.
- R7: The target core is the first qualifying core in circular order, starting at the core after the previous target. The search starts at core 0 after a launch.
- R8: kernelDone rises after all blocks of the grid have been transferred and every one has been returned. It stays high until the next launch. It is low after reset.
- R9: A coreDone pulse from a core that holds no block is ignored. It does not raise that core's capacity.
- R10: A launch request that arrives while a grid is still running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| launchValid | input | 1 | One-cycle launch request |
| gridBlocks | input | GRID_W (16) | Number of blocks in the grid |
| blockThreads | input | THR_W (11) | Threads per block |
| blockShmem | input | SHM_W (16) | Shared-memory bytes per block |
| issueValid | output | 1 | A block is offered |
| issueCore | output | IDX_W (2) | Core the offered block is meant for |
| issueBlock | output | GRID_W (16) | Index of the offered block |
| issueReady | input | NUM_CORES (4) | Per-core acceptance of an offer |
| coreDone | input | NUM_CORES (4) | Per-core pulse: one block finished |
| kernelDone | output | 1 | Whole grid issued and returned |
| launchError | output | 1 | Last launch was refused |

## Verification
The fill patterns use three block shapes: 128 threads with 520 bytes, 32 threads with no shared memory, and 64 threads with 8,192 bytes. Each shape is launched with returns held off, so the number of blocks a core accepts shows which of the three limits is binding. A single return after a full fill shows that freed capacity is reused by the right core. Further runs cover a core that withholds ready, which exposes the hold rule and the rotation, and a spurious return into an empty core, which would otherwise inflate the fill count. A relaunch while a grid is running, three refused shapes and an empty grid separate the launch, error and completion paths. A behavioural model predicts the offer channel and both flags every cycle.

// File: rtl/blkdisp_pkg.sv
package blkdisp_pkg;
  // Strobes from the control unit to the per-core resource pool.
  typedef struct packed {
    logic poolReset;  // refill every core and latch the new block shape
    logic reserve;    // take one block's resources from the selected core
  } poolCmd_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DONE  = 2'd2,
    ST_FAULT = 2'd3
  } dispState_t;
endpackage

// File: rtl/core_pool.sv
module core_pool
  import blkdisp_pkg::*;
#(
  parameter int NUM_CORES        = 4,
  parameter int THREADS_PER_CORE = 1536,
  parameter int SHMEM_PER_CORE   = 49152,
  parameter int SLOTS_PER_CORE   = 16,
  parameter int THR_W            = $clog2(THREADS_PER_CORE + 1),
  parameter int SHM_W            = $clog2(SHMEM_PER_CORE + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  poolCmd_t             cmd,
  input  logic [NUM_CORES-1:0] reserveSel,
  input  logic [THR_W-1:0]     needThr,
  input  logic [SHM_W-1:0]     needShm,
  input  logic [NUM_CORES-1:0] coreDone,
  output logic [NUM_CORES-1:0] fit,
  output logic                 allIdle
);
  localparam int SLOT_W = $clog2(SLOTS_PER_CORE + 1);
  localparam logic [THR_W-1:0]  THR_FULL  = THR_W'(THREADS_PER_CORE);
  localparam logic [SHM_W-1:0]  SHM_FULL  = SHM_W'(SHMEM_PER_CORE);
  localparam logic [SLOT_W-1:0] SLOT_FULL = SLOT_W'(SLOTS_PER_CORE);

  logic [THR_W-1:0] shapeThr;
  logic [SHM_W-1:0] shapeShm;
  logic [NUM_CORES-1:0] coreIdle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shapeThr <= '0;
      shapeShm <= '0;
    end else if (cmd.poolReset) begin
      shapeThr <= needThr;
      shapeShm <= needShm;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic [THR_W-1:0]  freeThr;
    logic [SHM_W-1:0]  freeShm;
    logic [SLOT_W-1:0] freeSlot;
    logic retire, take;

    // A return is honoured only when the core really holds a block.
    assign retire = coreDone[c] && (freeSlot != SLOT_FULL);
    assign take   = cmd.reserve && reserveSel[c];

    always_ff @(posedge clk) begin
      if (!rstN || cmd.poolReset) begin
        freeThr  <= THR_FULL;
        freeShm  <= SHM_FULL;
        freeSlot <= SLOT_FULL;
      end else begin
        freeThr  <= freeThr + (retire ? shapeThr : '0) - (take ? shapeThr : '0);
        freeShm  <= freeShm + (retire ? shapeShm : '0) - (take ? shapeShm : '0);
        freeSlot <= freeSlot + SLOT_W'(retire) - SLOT_W'(take);
      end
    end

    assign fit[c] = (freeThr >= shapeThr) && (freeShm >= shapeShm) && (freeSlot != '0);
    assign coreIdle[c] = (freeSlot == SLOT_FULL);
  end

  assign allIdle = &coreIdle;
endmodule

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import blkdisp_pkg::*;
#(
  parameter int NUM_CORES        = 4,
  parameter int GRID_W           = 16,
  parameter int THREADS_PER_CORE = 1536,
  parameter int SHMEM_PER_CORE   = 49152,
  parameter int THR_W            = $clog2(THREADS_PER_CORE + 1),
  parameter int SHM_W            = $clog2(SHMEM_PER_CORE + 1),
  parameter int IDX_W            = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 launchValid,
  input  logic [GRID_W-1:0]    gridBlocks,
  input  logic [THR_W-1:0]     blockThreads,
  input  logic [SHM_W-1:0]     blockShmem,
  input  logic [NUM_CORES-1:0] fit,
  input  logic                 allIdle,
  input  logic [NUM_CORES-1:0] issueReady,
  output poolCmd_t             cmd,
  output logic [NUM_CORES-1:0] reserveSel,
  output logic                 issueValid,
  output logic [IDX_W-1:0]     issueCore,
  output logic [GRID_W-1:0]    issueBlock,
  output logic                 kernelDone,
  output logic                 launchError
);
  localparam logic [THR_W-1:0] THR_CAP  = THR_W'(THREADS_PER_CORE);
  localparam logic [SHM_W-1:0] SHM_CAP  = SHM_W'(SHMEM_PER_CORE);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CORES - 1);

  dispState_t        state;
  logic [GRID_W-1:0] gridQ, nextIdx, offerBlk;
  logic [IDX_W-1:0]  offerCore, ptr, pickIdx, nextPtr;
  logic              offerValid, pickFound, fire, loadOffer, finished;
  logic              acceptLaunch, badReq;

  assign acceptLaunch = launchValid && (state != ST_RUN);
  assign badReq = (blockThreads == '0) || (blockThreads > THR_CAP) || (blockShmem > SHM_CAP);
  assign fire = offerValid && issueReady[offerCore];

  // Circular search for the first core with room, starting at ptr.
  always_comb begin
    int cand;
    pickFound = 1'b0;
    pickIdx   = '0;
    for (int k = 0; k < NUM_CORES; k++) begin
      cand = int'(ptr) + k;
      if (cand >= NUM_CORES) cand = cand - NUM_CORES;
      if (!pickFound && fit[cand]) begin
        pickFound = 1'b1;
        pickIdx   = IDX_W'(cand);
      end
    end
  end

  assign nextPtr   = (pickIdx == LAST_IDX) ? '0 : pickIdx + 1'b1;
  assign loadOffer = (state == ST_RUN) && (!offerValid || fire) && (nextIdx < gridQ) && pickFound;
  assign finished  = (state == ST_RUN) && (nextIdx == gridQ) && !offerValid && allIdle;

  always_comb begin
    cmd.poolReset = acceptLaunch && !badReq;
    cmd.reserve   = loadOffer;
    reserveSel    = '0;
    if (loadOffer) reserveSel[pickIdx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      gridQ      <= '0;
      nextIdx    <= '0;
      offerValid <= 1'b0;
      offerCore  <= '0;
      offerBlk   <= '0;
      ptr        <= '0;
    end else if (acceptLaunch) begin
      state      <= badReq ? ST_FAULT : ST_RUN;
      gridQ      <= gridBlocks;
      nextIdx    <= '0;
      offerValid <= 1'b0;
      ptr        <= '0;
    end else if (state == ST_RUN) begin
      if (loadOffer) begin
        offerValid <= 1'b1;
        offerCore  <= pickIdx;
        offerBlk   <= nextIdx;
        nextIdx    <= nextIdx + 1'b1;
        ptr        <= nextPtr;
      end else if (fire) begin
        offerValid <= 1'b0;
      end
      if (finished) state <= ST_DONE;
    end
  end

  assign issueValid  = offerValid;
  assign issueCore   = offerCore;
  assign issueBlock  = offerBlk;
  assign kernelDone  = (state == ST_DONE);
  assign launchError = (state == ST_FAULT);
endmodule

// File: rtl/block_dispatcher.sv
module block_dispatcher
  import blkdisp_pkg::*;
#(
  parameter int NUM_CORES        = 4,
  parameter int GRID_W           = 16,
  parameter int THREADS_PER_CORE = 1536,
  parameter int SHMEM_PER_CORE   = 49152,
  parameter int SLOTS_PER_CORE   = 16,
  localparam int THR_W = $clog2(THREADS_PER_CORE + 1),
  localparam int SHM_W = $clog2(SHMEM_PER_CORE + 1),
  localparam int IDX_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 launchValid,
  input  logic [GRID_W-1:0]    gridBlocks,
  input  logic [THR_W-1:0]     blockThreads,
  input  logic [SHM_W-1:0]     blockShmem,
  output logic                 issueValid,
  output logic [IDX_W-1:0]     issueCore,
  output logic [GRID_W-1:0]    issueBlock,
  input  logic [NUM_CORES-1:0] issueReady,
  input  logic [NUM_CORES-1:0] coreDone,
  output logic                 kernelDone,
  output logic                 launchError
);
  poolCmd_t             cmd;
  logic [NUM_CORES-1:0] reserveSel, fit;
  logic                 allIdle;

  dispatch_ctrl #(
    .NUM_CORES(NUM_CORES), .GRID_W(GRID_W), .THREADS_PER_CORE(THREADS_PER_CORE),
    .SHMEM_PER_CORE(SHMEM_PER_CORE), .THR_W(THR_W), .SHM_W(SHM_W), .IDX_W(IDX_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .launchValid(launchValid), .gridBlocks(gridBlocks),
    .blockThreads(blockThreads), .blockShmem(blockShmem), .fit(fit), .allIdle(allIdle),
    .issueReady(issueReady), .cmd(cmd), .reserveSel(reserveSel), .issueValid(issueValid),
    .issueCore(issueCore), .issueBlock(issueBlock), .kernelDone(kernelDone),
    .launchError(launchError)
  );

  core_pool #(
    .NUM_CORES(NUM_CORES), .THREADS_PER_CORE(THREADS_PER_CORE), .SHMEM_PER_CORE(SHMEM_PER_CORE),
    .SLOTS_PER_CORE(SLOTS_PER_CORE), .THR_W(THR_W), .SHM_W(SHM_W)
  ) u_pool (
    .clk(clk), .rstN(rstN), .cmd(cmd), .reserveSel(reserveSel), .needThr(blockThreads),
    .needShm(blockShmem), .coreDone(coreDone), .fit(fit), .allIdle(allIdle)
  );
endmodule

// File: rtl/block_dispatcher_chk.sv
module block_dispatcher_chk #(
  parameter int NUM_CORES = 4,
  parameter int GRID_W    = 16,
  parameter int IDX_W     = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 launchValid,
  input logic                 issueValid,
  input logic [IDX_W-1:0]     issueCore,
  input logic [GRID_W-1:0]    issueBlock,
  input logic [NUM_CORES-1:0] issueReady,
  input logic                 kernelDone,
  input logic                 launchError
);
  AST_OFFER_HELD: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && !issueReady[issueCore] |=> issueValid && $stable(issueCore) && $stable(issueBlock)); // R6

  AST_INDEX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    issueValid && issueReady[issueCore] |=> !issueValid || (issueBlock == GRID_W'($past(issueBlock) + 1'b1))); // R5

  AST_FAULT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    launchError |-> !issueValid && !kernelDone); // R1

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    launchError && !launchValid |=> launchError); // R1

  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    kernelDone && !launchValid |=> kernelDone && !issueValid); // R8
endmodule

bind block_dispatcher block_dispatcher_chk #(
  .NUM_CORES(NUM_CORES), .GRID_W(GRID_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/block_dispatcher_test.sv
module block_dispatcher_test;
  localparam int NC = 4;
  localparam int THR_CAP = 1536;
  localparam int SHM_CAP = 49152;
  localparam int SLOT_CAP = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic launchValid = 1'b0;
  logic [15:0] gridBlocks = '0;
  logic [10:0] blockThreads = '0;
  logic [15:0] blockShmem = '0;
  logic issueValid, kernelDone, launchError;
  logic [1:0] issueCore;
  logic [15:0] issueBlock;
  logic [NC-1:0] issueReady = '0;
  logic [NC-1:0] coreDone = '0;

  always #10 clk = ~clk;  // 50 MHz

  block_dispatcher uut (.*);

  int checks = 0, failures = 0, cyc = 0;

  // ---------------- behavioural reference model ----------------
  int mState, mGrid, mNext, mOffCore, mOffBlk, mPtr, mNeedT, mNeedS;
  bit mOffV;
  int mThr[NC], mShm[NC], mSlot[NC];

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; mGrid = 0; mNext = 0; mOffV = 0; mOffCore = 0; mOffBlk = 0; mPtr = 0;
      mNeedT = 0; mNeedS = 0;
      for (int c = 0; c < NC; c++) begin mThr[c] = THR_CAP; mShm[c] = SHM_CAP; mSlot[c] = SLOT_CAP; end
    end else begin
      bit fireM, acc, bad, found, load, fin, allEmpty;
      int pk;
      fireM = mOffV && issueReady[mOffCore];
      acc = launchValid && (mState != 1);
      bad = (blockThreads == 0) || (int'(blockThreads) > THR_CAP) || (int'(blockShmem) > SHM_CAP);
      found = 0; pk = 0;
      for (int k = 0; k < NC; k++) begin
        int cd;
        cd = (mPtr + k) % NC;
        if (!found && mThr[cd] >= mNeedT && mShm[cd] >= mNeedS && mSlot[cd] > 0) begin
          found = 1; pk = cd;
        end
      end
      load = !acc && (mState == 1) && (!mOffV || fireM) && (mNext < mGrid) && found;
      allEmpty = 1;
      for (int c = 0; c < NC; c++) if (mSlot[c] != SLOT_CAP) allEmpty = 0;
      fin = !acc && (mState == 1) && (mNext == mGrid) && !mOffV && allEmpty;
      if (acc && !bad) begin
        for (int c = 0; c < NC; c++) begin mThr[c] = THR_CAP; mShm[c] = SHM_CAP; mSlot[c] = SLOT_CAP; end
        mNeedT = int'(blockThreads); mNeedS = int'(blockShmem);
      end else begin
        for (int c = 0; c < NC; c++)
          if (coreDone[c] && mSlot[c] < SLOT_CAP) begin
            mThr[c] += mNeedT; mShm[c] += mNeedS; mSlot[c] += 1;
          end
        if (load) begin mThr[pk] -= mNeedT; mShm[pk] -= mNeedS; mSlot[pk] -= 1; end
      end
      if (acc) begin
        mState = bad ? 3 : 1; mGrid = int'(gridBlocks); mNext = 0; mOffV = 0; mPtr = 0;
      end else if (mState == 1) begin
        if (load) begin
          mOffV = 1; mOffCore = pk; mOffBlk = mNext; mNext++; mPtr = (pk + 1) % NC;
        end else if (fireM) mOffV = 0;
        if (fin) mState = 2;
      end
    end
  end

  // ---------------- bench bookkeeping ----------------
  bit [NC-1:0] readyMask = '0;
  bit [NC-1:0] oneDone = '0;
  bit autoRet = 0;
  bit pendLaunch = 0;
  int expBlk = 0, totalFired = 0, fireCount = 0;
  int resident[NC], perCore[NC], coreSeq[8];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    @(negedge clk);
    cyc++;
    if (rstN) begin
      chk(issueValid == mOffV, "R6 issueValid vs model", int'(issueValid), int'(mOffV));
      if (mOffV && issueValid) begin
        chk(int'(issueCore) == mOffCore, "R7 issueCore vs model", int'(issueCore), mOffCore);
        chk(int'(issueBlock) == mOffBlk, "R5 issueBlock vs model", int'(issueBlock), mOffBlk);
      end
      chk(kernelDone == (mState == 2), "R8 kernelDone vs model", int'(kernelDone), int'(mState == 2));
      chk(launchError == (mState == 3), "R1 launchError vs model", int'(launchError), int'(mState == 3));
    end
    // returns are decided before this cycle's transfer is counted
    for (int c = 0; c < NC; c++) begin
      bit d;
      d = oneDone[c] || (autoRet && resident[c] > 0 && ((cyc + c) % 3 == 0));
      if (d && resident[c] > 0) resident[c]--;
      coreDone[c] = d;
    end
    oneDone = '0;
    if (issueValid && readyMask[issueCore]) begin
      chk(int'(issueBlock) == expBlk, "R5 increasing block index", int'(issueBlock), expBlk);
      expBlk++;
      totalFired++;
      resident[issueCore]++;
      perCore[issueCore]++;
      if (fireCount < 8) coreSeq[fireCount] = int'(issueCore);
      fireCount++;
    end
    issueReady = readyMask;
    launchValid = pendLaunch;
    pendLaunch = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic launch(input int grid, input int thr, input int shm, input bit accepted);
    gridBlocks = 16'(grid); blockThreads = 11'(thr); blockShmem = 16'(shm);
    pendLaunch = 1;
    if (accepted) begin
      expBlk = 0; totalFired = 0; fireCount = 0;
      for (int c = 0; c < NC; c++) perCore[c] = 0;
    end
  endtask

  task automatic finishGrid(input int grid, input string tag);
    int guard;
    guard = 0;
    readyMask = '1; autoRet = 1;
    while (!kernelDone && guard < 5000) begin step(); guard++; end
    chk(kernelDone == 1'b1, tag, int'(kernelDone), 1);
    chk(totalFired == grid, "R5 total blocks handed over", totalFired, grid);
    autoRet = 0;
  endtask

  initial begin
    #(20 * 150000);
    failures++;
    $display("FAIL watchdog expired (cycle %0d)", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int c = 0; c < NC; c++) begin resident[c] = 0; perCore[c] = 0; end
    run(3);
    rstN = 1'b1;
    run(2);
    chk(!issueValid && !kernelDone && !launchError, "R8 reset state idle", int'(issueValid), 0);

    // R3/R7: fill with 128-thread, 520-byte blocks, no returns
    readyMask = '1;
    launch(100, 128, 520, 1);
    run(80);
    for (int c = 0; c < NC; c++) chk(perCore[c] == 12, "R3 blocks per core at thread limit", perCore[c], 12);
    chk(issueValid == 1'b0, "R2 no offer when no core has room", int'(issueValid), 0);
    chk(coreSeq[0] == 0 && coreSeq[1] == 1 && coreSeq[2] == 2 && coreSeq[3] == 3 && coreSeq[4] == 0,
        "R7 rotation order of first transfers", coreSeq[4], 0);
    // R4: one return on core 2 lets exactly one more block go there
    oneDone = 4'b0100;
    run(6);
    chk(perCore[2] == 13, "R4 freed slot reused by core 2", perCore[2], 13);
    chk(totalFired == 49, "R4 only one extra block", totalFired, 49);
    finishGrid(100, "R8 kernelDone after full grid");
    run(3);
    chk(kernelDone == 1'b1, "R8 kernelDone stays high", int'(kernelDone), 1);

    // R9/R10: spurious return on an idle core, relaunch during run
    readyMask = '1;
    launch(50, 128, 520, 1);
    step();
    oneDone = 4'b1000;
    run(4);
    launch(5, 32, 0, 0);
    run(70);
    chk(perCore[3] == 12, "R9 spurious return left capacity unchanged", perCore[3], 12);
    finishGrid(50, "R10 relaunch ignored, grid of 50 completes");

    // R2: slot limit and shared-memory limit
    launch(100, 32, 0, 1);
    run(90);
    for (int c = 0; c < NC; c++) chk(perCore[c] == 16, "R2 slot limit per core", perCore[c], 16);
    finishGrid(100, "R2 slot-limited grid completes");
    launch(40, 64, 8192, 1);
    run(40);
    for (int c = 0; c < NC; c++) chk(perCore[c] == 6, "R2 shared-memory limit per core", perCore[c], 6);
    finishGrid(40, "R2 shmem-limited grid completes");

    // R6: core 2 withholds ready, offer must hold
    readyMask = 4'b1011;
    launch(20, 128, 520, 1);
    run(12);
    chk(issueValid && issueCore == 2'd2 && issueBlock == 16'd2, "R6 stalled offer held for core 2",
        int'(issueBlock), 2);
    finishGrid(20, "R6 grid completes after stall");

    // R1: refused launches
    readyMask = '1;
    launch(10, 1537, 0, 1);
    run(3);
    chk(launchError == 1'b1, "R1 too many threads refused", int'(launchError), 1);
    launch(10, 0, 0, 1);
    run(3);
    chk(launchError == 1'b1, "R1 zero threads refused", int'(launchError), 1);
    launch(10, 64, 49153, 1);
    run(5);
    chk(launchError == 1'b1 && !issueValid, "R1 too much shared memory refused", int'(launchError), 1);
    chk(totalFired == 0, "R1 nothing issued after refusal", totalFired, 0);

    // R8: empty grid completes with no transfers
    launch(0, 64, 0, 1);
    run(4);
    chk(kernelDone == 1'b1 && !launchError, "R8 empty grid done", int'(kernelDone), 1);
    chk(totalFired == 0, "R5 empty grid hands over nothing", totalFired, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule